// File: doc/BRIEF.md
# Event Counter Performance Monitor

This block counts hardware events for performance analysis. A small, parameterised bank of 32-bit counters (eight counters split into two groups by default) watches a vector of event pulses. Each pulse lasts one cycle, and each bit position is one event class. Every counter holds its own event-class selector, so it follows exactly one class. Software sets up and reads the block through a simple 32-bit register port. A write takes effect at the clock edge where it is presented. Read data appears on `bus_rdata` one cycle after the read strobe and then holds until the next read.

Counting is gated in layers. A global enable comes first, then a per-group enable, then a per-counter enable. The per-counter enable, the per-counter interrupt enable and the overflow status are held as bitmaps. Software changes them only through write-one set, write-one clear and write-one-to-clear registers, never by read-modify-write. A counter that wraps raises its overflow status bit. A single level interrupt output is high while any raised overflow bit has its interrupt enabled.

Byte address map (12-bit address, 4-byte stride everywhere):

| Address | Contents |
|---|---|
| 0x000 | control: bit 0 global enable, bit 1 counter reset (write 1) |
| 0x004 | read-only configuration |
| 0x040 + 4g | control for group g |
| 0x100 / 0x180 | counter-enable set / clear |
| 0x200 / 0x280 | interrupt-enable set / clear |
| 0x300 | overflow status |
| 0x400 + 4i | event type of counter i, bits [7:0] |
| 0x800 + 4i | count of counter i |

Counter i belongs to group i / (counters per group).

Top module: `pmu_event_monitor`

## Requirements
- R1: After system reset, every counter, global and group enable, counter enable, interrupt enable and overflow bit is zero, and `irq` is low.
- R2: The read-only configuration register at 0x004 returns the total number of counters in bits [7:0] and the number of groups in bits [31:24]. Each group control register returns its enable in bit 11 and the number of counters in the group in bits [27:24].
- R3: A counter adds one in a cycle only if all of the following hold in that cycle: the global enable (bit 0 at 0x000) is set, its group's bit 11 is set, its own counter-enable bit is set, and the event input selected by its type register is high.
- R4: The counter-enable bitmap is written through set and clear registers. So is the interrupt-enable bitmap. Counter i sits in register i/32, bit i%32. A 1 sets or clears that bit, and a 0 leaves it unchanged. Reading either the set register or the clear register returns the current bitmap.
- R5: Writing 1 to bit 1 of 0x000 zeroes every counter. That bit reads back as 0, and bit 0 of the same write sets the global enable.
- R6: A counter that wraps from all ones to zero sets its overflow bit (0x300, same bit layout as R4). Writing 1 clears the bit and writing 0 has no effect. If a wrap and a clear of the same bit fall in the same cycle, the bit ends up set.
- R7: `irq` is high exactly when some counter has both its overflow bit and its interrupt-enable bit set.
- R8: Writing a count register loads the written value. If the write and an increment fall in the same cycle, the written value is kept.
- R9: The event type register (bits [7:0]) selects which event input a counter follows. Pulses on other inputs do not change that counter.
- R10: Read data is registered. It is valid on `bus_rdata` one cycle after `bus_rd` and holds while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| evt_in | input | NUM_EVT | One-cycle event pulses, one bit per event class |
| irq | output | 1 | Level interrupt on an enabled overflow |

## Verification
A counter overflows only when it wraps past all ones, and no event stream through the ports could take it there in a test of reasonable length. The stimulus therefore loads a count register with all ones and then sends a single matching pulse. The hardest case is a wrap and a write-one-to-clear of the same overflow bit in the same cycle. The bench reaches it by driving the matching event pulse and the status write in one cycle. It also drives a count write together with an increment in one cycle, to show that the loaded value is kept.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
    localparam int ADDR_W = 12;
    localparam int TYPE_W = 8;

    localparam logic [ADDR_W-1:0] A_CTRL  = 12'h000;
    localparam logic [ADDR_W-1:0] A_CFG   = 12'h004;
    localparam logic [ADDR_W-1:0] A_GRP   = 12'h040;
    localparam logic [ADDR_W-1:0] A_ENSET = 12'h100;
    localparam logic [ADDR_W-1:0] A_ENCLR = 12'h180;
    localparam logic [ADDR_W-1:0] A_IESET = 12'h200;
    localparam logic [ADDR_W-1:0] A_IECLR = 12'h280;
    localparam logic [ADDR_W-1:0] A_OVF   = 12'h300;
    localparam logic [ADDR_W-1:0] A_TYPE  = 12'h400;
    localparam logic [ADDR_W-1:0] A_CNT   = 12'h800;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_RST_BIT = 1;
    localparam int GRP_EN_BIT   = 11;

    // address of the idx-th word above a base
    function automatic logic [ADDR_W-1:0] slot(logic [ADDR_W-1:0] base, int idx);
        return base + ADDR_W'(4 * idx);
    endfunction
endpackage

// File: rtl/pmon_slice.sv
module pmon_slice
    import pmon_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int NUM_EVT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               count_ok,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic               en_set,
    input  logic               en_clr,
    input  logic               ie_set,
    input  logic               ie_clr,
    input  logic               ovf_clr,
    input  logic               type_we,
    input  logic               cnt_we,
    input  logic               cnt_zero,
    input  logic [31:0]        wdata,
    output logic [CNT_W-1:0]   cnt,
    output logic               en,
    output logic               ie,
    output logic               ovf,
    output logic [TYPE_W-1:0]  evt_sel
);
    logic [NUM_EVT-1:0] sel_mask;
    logic               hit;
    logic               inc;
    logic               wrap;

    always_comb begin
        sel_mask = {{(NUM_EVT-1){1'b0}}, 1'b1} << evt_sel;
        hit      = |(evt_in & sel_mask);
        inc      = count_ok && en && hit;
        wrap     = inc && !cnt_zero && !cnt_we && (cnt == {CNT_W{1'b1}});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            en      <= 1'b0;
            ie      <= 1'b0;
            ovf     <= 1'b0;
            evt_sel <= '0;
        end else begin
            if (cnt_zero)    cnt <= '0;
            else if (cnt_we) cnt <= wdata[CNT_W-1:0];
            else if (inc)    cnt <= cnt + 1'b1;

            if (wrap)         ovf <= 1'b1;
            else if (ovf_clr) ovf <= 1'b0;

            if (en_set)      en <= 1'b1;
            else if (en_clr) en <= 1'b0;

            if (ie_set)      ie <= 1'b1;
            else if (ie_clr) ie <= 1'b0;

            if (type_we) evt_sel <= wdata[TYPE_W-1:0];
        end
    end
endmodule

// File: rtl/pmon_rdmux.sv
module pmon_rdmux
    import pmon_pkg::*;
#(
    parameter int NUM_CNT = 8,
    parameter int NUM_GRP = 2,
    parameter int CNT_W   = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      glb_en,
    input  logic [NUM_GRP-1:0]        grp_en,
    input  logic [NUM_CNT-1:0]        en_vec,
    input  logic [NUM_CNT-1:0]        ie_vec,
    input  logic [NUM_CNT-1:0]        ovf_vec,
    input  logic [NUM_CNT*CNT_W-1:0]  cnt_flat,
    input  logic [NUM_CNT*TYPE_W-1:0] type_flat,
    output logic [31:0]               rdata
);
    localparam int CPG = NUM_CNT / NUM_GRP;

    logic [31:0] rd_next;

    always_comb begin
        rd_next = '0;
        if (addr == A_CTRL) rd_next[CTRL_EN_BIT] = glb_en;
        if (addr == A_CFG) begin
            rd_next[7:0]   = 8'(NUM_CNT);
            rd_next[31:24] = 8'(NUM_GRP);
        end
        for (int g = 0; g < NUM_GRP; g++) begin
            if (addr == slot(A_GRP, g)) begin
                rd_next[GRP_EN_BIT] = grp_en[g];
                rd_next[27:24]      = 4'(CPG);
            end
        end
        for (int i = 0; i < NUM_CNT; i++) begin
            if (addr == slot(A_ENSET, i / 32) || addr == slot(A_ENCLR, i / 32))
                rd_next[i % 32] = en_vec[i];
            if (addr == slot(A_IESET, i / 32) || addr == slot(A_IECLR, i / 32))
                rd_next[i % 32] = ie_vec[i];
            if (addr == slot(A_OVF, i / 32))
                rd_next[i % 32] = ovf_vec[i];
            if (addr == slot(A_TYPE, i))
                rd_next[TYPE_W-1:0] = type_flat[i*TYPE_W +: TYPE_W];
            if (addr == slot(A_CNT, i))
                rd_next[CNT_W-1:0] = cnt_flat[i*CNT_W +: CNT_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_next;
    end
endmodule

// File: rtl/pmu_event_monitor.sv
module pmu_event_monitor
    import pmon_pkg::*;
#(
    parameter int NUM_CNT = 8,
    parameter int NUM_GRP = 2,
    parameter int NUM_EVT = 16,
    parameter int CNT_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [11:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic               irq
);
    localparam int CPG = NUM_CNT / NUM_GRP;

    logic                      glb_en;
    logic [NUM_GRP-1:0]        grp_en;
    logic [NUM_CNT-1:0]        en_vec;
    logic [NUM_CNT-1:0]        ie_vec;
    logic [NUM_CNT-1:0]        ovf_vec;
    logic [NUM_CNT*CNT_W-1:0]  cnt_flat;
    logic [NUM_CNT*TYPE_W-1:0] type_flat;
    logic                      cnt_zero;

    assign cnt_zero = bus_wr && (bus_addr == A_CTRL) && bus_wdata[CTRL_RST_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glb_en <= 1'b0;
        end else if (bus_wr && bus_addr == A_CTRL) begin
            glb_en <= bus_wdata[CTRL_EN_BIT];
        end
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                grp_en[g] <= 1'b0;
            end else if (bus_wr && bus_addr == slot(A_GRP, g)) begin
                grp_en[g] <= bus_wdata[GRP_EN_BIT];
            end
        end
    end

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        logic wr_bit;
        assign wr_bit = bus_wr && bus_wdata[i % 32];

        pmon_slice #(
            .CNT_W   (CNT_W),
            .NUM_EVT (NUM_EVT)
        ) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .count_ok (glb_en && grp_en[i / CPG]),
            .evt_in   (evt_in),
            .en_set   (wr_bit && bus_addr == slot(A_ENSET, i / 32)),
            .en_clr   (wr_bit && bus_addr == slot(A_ENCLR, i / 32)),
            .ie_set   (wr_bit && bus_addr == slot(A_IESET, i / 32)),
            .ie_clr   (wr_bit && bus_addr == slot(A_IECLR, i / 32)),
            .ovf_clr  (wr_bit && bus_addr == slot(A_OVF, i / 32)),
            .type_we  (bus_wr && bus_addr == slot(A_TYPE, i)),
            .cnt_we   (bus_wr && bus_addr == slot(A_CNT, i)),
            .cnt_zero (cnt_zero),
            .wdata    (bus_wdata),
            .cnt      (cnt_flat[i*CNT_W +: CNT_W]),
            .en       (en_vec[i]),
            .ie       (ie_vec[i]),
            .ovf      (ovf_vec[i]),
            .evt_sel  (type_flat[i*TYPE_W +: TYPE_W])
        );
    end

    pmon_rdmux #(
        .NUM_CNT (NUM_CNT),
        .NUM_GRP (NUM_GRP),
        .CNT_W   (CNT_W)
    ) u_rdmux (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (bus_rd),
        .addr      (bus_addr),
        .glb_en    (glb_en),
        .grp_en    (grp_en),
        .en_vec    (en_vec),
        .ie_vec    (ie_vec),
        .ovf_vec   (ovf_vec),
        .cnt_flat  (cnt_flat),
        .type_flat (type_flat),
        .rdata     (bus_rdata)
    );

    assign irq = |(ovf_vec & ie_vec);
endmodule

// File: rtl/pmon_checker.sv
module pmon_checker
    import pmon_pkg::*;
#(
    parameter int NUM_CNT = 8,
    parameter int CNT_W   = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_wr,
    input logic                     bus_rd,
    input logic [11:0]              bus_addr,
    input logic                     wr_rst_bit,
    input logic [31:0]              bus_rdata,
    input logic                     irq,
    input logic                     glb_en,
    input logic [NUM_CNT-1:0]       ie_vec,
    input logic [NUM_CNT-1:0]       ovf_vec,
    input logic [NUM_CNT*CNT_W-1:0] cnt_flat
);
    logic ovf_wr;
    assign ovf_wr = bus_wr && (bus_addr[11:7] == A_OVF[11:7]);

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R5
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CTRL && wr_rst_bit) |=> (cnt_flat == '0));

    // R3
    idle_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_en && !bus_wr) |=> $stable(cnt_flat));

    // R7
    irq_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_vec == '0) |-> !irq);

    // R7
    irq_needs_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ovf_vec != '0));

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_wr |=> ((ovf_vec & $past(ovf_vec)) == $past(ovf_vec)));
endmodule

bind pmu_event_monitor pmon_checker #(
    .NUM_CNT (NUM_CNT),
    .CNT_W   (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .wr_rst_bit (bus_wdata[1]),
    .bus_rdata  (bus_rdata),
    .irq        (irq),
    .glb_en     (glb_en),
    .ie_vec     (ie_vec),
    .ovf_vec    (ovf_vec),
    .cnt_flat   (cnt_flat)
);

// File: tb/pmu_event_monitor_tb.sv
`timescale 1ns/1ps
module pmu_event_monitor_tb;
    localparam int NEVT = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr = 1'b0;
    logic            bus_rd = 1'b0;
    logic [11:0]     bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NEVT-1:0] evt_in = '0;
    logic            irq;

    int n_vec = 0;
    int n_bad = 0;
    logic            rd_issued = 1'b0;
    logic [31:0]     exp_q[$];
    string           tag_q[$];

    always #2 clk = ~clk;

    pmu_event_monitor u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt_in    (evt_in),
        .irq       (irq)
    );

    // monitor: a read issued in cycle t is compared at the next falling edge
    always @(posedge clk) rd_issued <= bus_rd;

    always @(negedge clk) begin
        if (rd_issued && exp_q.size() > 0) begin
            logic [31:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_vec++;
            if (bus_rdata !== e) begin
                n_bad++;
                $display("FAIL %s: rdata=%h expected=%h", t, bus_rdata, e);
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input int idx);
        @(negedge clk);
        evt_in[idx] = 1'b1;
        @(negedge clk);
        evt_in = '0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        @(negedge clk);
        n_vec++;
        if (irq !== e) begin
            n_bad++;
            $display("FAIL %s: irq=%b expected=%b", t, irq, e);
        end
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: run=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(12'h000, 32'h0, "R1 ctrl");
        rd(12'h100, 32'h0, "R1 enable map");
        rd(12'h800, 32'h0, "R1 count0");
        rd(12'h300, 32'h0, "R1 overflow");
        chk_irq(1'b0, "R1 irq");
        // R2 configuration
        rd(12'h004, 32'h0200_0008, "R2 config");
        rd(12'h044, 32'h0400_0000, "R2 group1");
        // R9 event types: counter0 -> class 3, counter5 -> class 7
        wr(12'h400, 32'd3);
        wr(12'h414, 32'd7);
        rd(12'h414, 32'd7, "R9 type5");
        // R4 set
        wr(12'h100, 32'h21);
        rd(12'h100, 32'h21, "R4 set readback");
        rd(12'h180, 32'h21, "R4 clear readback");
        // R3 layered gating
        pulse(3);
        rd(12'h800, 32'd0, "R3 global off");
        wr(12'h000, 32'h1);
        pulse(3);
        rd(12'h800, 32'd0, "R3 group off");
        wr(12'h040, 32'h800);
        pulse(3);
        pulse(3);
        rd(12'h800, 32'd2, "R3 all on");
        rd(12'h040, 32'h0400_0800, "R2 group0");
        pulse(7);
        rd(12'h814, 32'd0, "R3 group1 off");
        rd(12'h800, 32'd2, "R9 other class");
        wr(12'h044, 32'h800);
        pulse(7);
        rd(12'h814, 32'd1, "R9 class7");
        // R4 clear / zero no effect
        wr(12'h180, 32'h01);
        rd(12'h100, 32'h20, "R4 clear");
        wr(12'h100, 32'h00);
        rd(12'h100, 32'h20, "R4 zero no effect");
        pulse(3);
        rd(12'h800, 32'd2, "R3 counter off");
        wr(12'h100, 32'h01);
        // R5 global reset
        wr(12'h000, 32'h3);
        rd(12'h800, 32'd0, "R5 count0");
        rd(12'h814, 32'd0, "R5 count5");
        rd(12'h000, 32'h1, "R5 ctrl readback");
        // R8 load, R6 wrap
        wr(12'h800, 32'hFFFF_FFFF);
        rd(12'h800, 32'hFFFF_FFFF, "R8 load");
        pulse(3);
        rd(12'h800, 32'd0, "R6 wrapped");
        rd(12'h300, 32'h1, "R6 overflow set");
        chk_irq(1'b0, "R7 no ie");
        wr(12'h200, 32'h1);
        chk_irq(1'b1, "R7 ie on");
        rd(12'h280, 32'h1, "R4 ie readback");
        wr(12'h300, 32'h0);
        rd(12'h300, 32'h1, "R6 zero no effect");
        wr(12'h300, 32'h1);
        rd(12'h300, 32'h0, "R6 w1c");
        chk_irq(1'b0, "R7 cleared");
        // R6 set wins over simultaneous clear
        wr(12'h800, 32'hFFFF_FFFF);
        @(negedge clk);
        evt_in[3] = 1'b1;
        bus_wr = 1'b1; bus_addr = 12'h300; bus_wdata = 32'h1;
        @(negedge clk);
        evt_in = '0; bus_wr = 1'b0;
        rd(12'h300, 32'h1, "R6 set wins");
        chk_irq(1'b1, "R7 pending");
        wr(12'h280, 32'h1);
        chk_irq(1'b0, "R7 ie cleared");
        // R8 write wins over increment
        @(negedge clk);
        evt_in[3] = 1'b1;
        bus_wr = 1'b1; bus_addr = 12'h800; bus_wdata = 32'd10;
        @(negedge clk);
        evt_in = '0; bus_wr = 1'b0;
        rd(12'h800, 32'd10, "R8 write wins");
        // R10 hold between reads
        repeat (3) @(negedge clk);
        n_vec++;
        if (bus_rdata !== 32'd10) begin
            n_bad++;
            $display("FAIL R10 hold: rdata=%h expected=%h", bus_rdata, 32'd10);
        end
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule